// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date in packed BCD registers. A tick input is divided down by a parameterised prescaler to one advance per second. Each advance steps seconds, and carries ripple through minutes, hours, day of month, month and a two-digit year covering 2000 to 2099. A day-of-week counter moves together with the date. Month lengths and the leap-year rule are applied when the date wraps.

A host reaches every field through a byte-addressed register port. Writes take effect on the next clock edge, and reads are combinational. One control bit selects a 12-hour presentation of the hour byte. In that mode the hour is read and written as 1 to 12 with a PM marker. Another control bit freezes time. A sticky integrity flag sits in the top bit of the seconds byte. It is set by reset or by an oscillator-fail input, and a seconds write with that bit at zero clears it.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, weekday and year read 00, date and month read 01, control reads 00, and the integrity flag (seconds byte bit 7) reads 1, so the seconds byte reads 0x80.
- R2: The control register is at address 0x00; bit 3 is the 12-hour mode and bit 5 is stop, and its other bits read 0. Seconds, minutes, hours, date, weekday, month and year are at addresses 0x03 to 0x09 in that order. Any other address reads 0x00.
- R3: Seconds advance by one on the TICKS_PER_SEC-th tick_in pulse counted since the prescaler was last cleared; fewer pulses leave the time unchanged.
- R4: Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 (24-hour value) wrap to 00 and carry into the date.
- R5: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February.
- R6: February wraps after 29 when the BCD year value is divisible by 4 (including 00), and after 28 otherwise.
- R7: A date wrap carries into the month. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R8: The weekday (0 to 6) advances on every date carry and wraps from 6 to 0.
- R9: With 12-hour mode set, the hour byte reads 1 to 12 in BCD in bits 4:0, and bit 5 is set for PM. Midnight reads 0x12 and noon reads 0x32.
- R10: With 12-hour mode set, a written hour byte is taken as 1 to 12 with bit 5 as PM. A write of 0x12 is midnight and a write of 0x32 is noon.
- R11: While stop is set, ticks do not change any time field.
- R12: A field write takes effect on the next clock edge. A seconds write also clears the prescaler and cancels any advance due in that cycle.
- R13: The integrity flag is set while osc_fail is high. It is cleared by a seconds write with bit 7 at 0 when osc_fail is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Sub-second tick pulse, one cycle wide |
| osc_fail | input | 1 | Oscillator failure indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
A wrong carry or month-length decision does not show up at once. It appears at the ports only when the bench reads the fields after the exact second that crosses the boundary. For that reason every boundary vector is loaded one second before the rollover and read right after it. A bad prescaler phase shows as a seconds value that is off by one, one tick early or late. A mishandled hour conversion is visible in the same cycle, because reads are combinational.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;    // always 24-hour BCD internally
    } tod_t;

    typedef struct packed {
        bcd8_t      date;
        logic [2:0] wday;
        bcd8_t      month;
        bcd8_t      year;
    } cal_t;

    localparam int A_CTRL  = 0;
    localparam int A_SEC   = 3;
    localparam int A_MIN   = 4;
    localparam int A_HOUR  = 5;
    localparam int A_DATE  = 6;
    localparam int A_WDAY  = 7;
    localparam int A_MONTH = 8;
    localparam int A_YEAR  = 9;

    localparam int CTRL_MODE12_BIT = 3;
    localparam int CTRL_STOP_BIT   = 5;
    localparam int HOUR_PM_BIT     = 5;

    function automatic bcd8_t bcd_inc(input bcd8_t b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        else                return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd2bin(input bcd8_t b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic bcd8_t bin2bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic year_is_leap(input bcd8_t y);
        if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else              return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic bcd8_t month_last_day(input bcd8_t m, input bcd8_t y);
        case (m)
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic bcd8_t hour_to_12(input bcd8_t h24);
        logic [6:0] hb;
        hb = bcd2bin(h24);
        if (hb == 7'd0)       return 8'h12;
        else if (hb < 7'd12)  return h24;
        else if (hb == 7'd12) return 8'h32;
        else                  return bin2bcd(hb - 7'd12) | 8'h20;
    endfunction

    function automatic logic [5:0] hour_from_12(input bcd8_t w);
        logic [6:0] hb;
        logic [6:0] r;
        hb = bcd2bin({3'b000, w[4:0]});
        if (hb == 7'd12) r = w[HOUR_PM_BIT] ? 7'd12 : 7'd0;
        else             r = w[HOUR_PM_BIT] ? hb + 7'd12 : hb;
        return 6'(bin2bcd(r));
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    input  logic clr,
    output logic carry
);
    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign carry = tick & ~hold & ~clr;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
            logic [CW-1:0] cnt_q;

            assign carry = tick & ~hold & ~clr & (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q <= '0;
                end else if (tick && !hold) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cal_tod_core.sv
module cal_tod_core
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hour,
    input  logic [6:0] wdata,
    input  logic [5:0] whour,
    output tod_t       q,
    output logic       day_carry
);
    tod_t d;
    logic sec_wrap, min_wrap, hr_wrap;

    assign sec_wrap  = q.sec  >= 8'h59;
    assign min_wrap  = q.min  >= 8'h59;
    assign hr_wrap   = q.hour >= 8'h23;
    assign day_carry = adv & sec_wrap & min_wrap & hr_wrap;

    always_comb begin
        d = q;
        if (adv) begin
            d.sec = sec_wrap ? 8'h00 : bcd_inc(q.sec);
            if (sec_wrap) begin
                d.min = min_wrap ? 8'h00 : bcd_inc(q.min);
                if (min_wrap) d.hour = hr_wrap ? 8'h00 : bcd_inc(q.hour);
            end
        end
        if (wr_sec)  d.sec  = {1'b0, wdata};
        if (wr_min)  d.min  = {1'b0, wdata};
        if (wr_hour) d.hour = {2'b00, whour};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00};
        else     q <= d;
    end
endmodule

// File: rtl/cal_date_core.sv
module cal_date_core
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr_date,
    input  logic       wr_wday,
    input  logic       wr_month,
    input  logic       wr_year,
    input  logic [7:0] wdata,
    output cal_t       q
);
    cal_t d;
    logic date_wrap, month_wrap, year_wrap;

    assign date_wrap  = q.date  >= month_last_day(q.month, q.year);
    assign month_wrap = q.month >= 8'h12;
    assign year_wrap  = q.year  >= 8'h99;

    always_comb begin
        d = q;
        if (adv) begin
            d.wday = (q.wday >= 3'd6) ? 3'd0 : q.wday + 3'd1;
            d.date = date_wrap ? 8'h01 : bcd_inc(q.date);
            if (date_wrap) begin
                d.month = month_wrap ? 8'h01 : bcd_inc(q.month);
                if (month_wrap) d.year = year_wrap ? 8'h00 : bcd_inc(q.year);
            end
        end
        if (wr_date)  d.date  = {2'b00, wdata[5:0]};
        if (wr_wday)  d.wday  = wdata[2:0];
        if (wr_month) d.month = {3'b000, wdata[4:0]};
        if (wr_year)  d.year  = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{date: 8'h01, wday: 3'd0, month: 8'h01, year: 8'h00};
        else     q <= d;
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int TICKS_PER_SEC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              osc_fail,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic mode12_q, stop_q, flag_q;
    logic sec_adv, day_adv;
    tod_t tod_q;
    cal_t cal_q;
    logic wr_ctrl, wr_sec, wr_min, wr_hour;
    logic wr_date, wr_wday, wr_month, wr_year;
    logic [5:0] hour_in;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_sec   = wr_en && (addr == ADDR_W'(A_SEC));
    assign wr_min   = wr_en && (addr == ADDR_W'(A_MIN));
    assign wr_hour  = wr_en && (addr == ADDR_W'(A_HOUR));
    assign wr_date  = wr_en && (addr == ADDR_W'(A_DATE));
    assign wr_wday  = wr_en && (addr == ADDR_W'(A_WDAY));
    assign wr_month = wr_en && (addr == ADDR_W'(A_MONTH));
    assign wr_year  = wr_en && (addr == ADDR_W'(A_YEAR));

    assign hour_in = mode12_q ? hour_from_12(wdata) : wdata[5:0];

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_in),
        .hold  (stop_q),
        .clr   (wr_sec),
        .carry (sec_adv)
    );

    cal_tod_core u_tod (
        .clk       (clk),
        .rst       (rst),
        .adv       (sec_adv),
        .wr_sec    (wr_sec),
        .wr_min    (wr_min),
        .wr_hour   (wr_hour),
        .wdata     (wdata[6:0]),
        .whour     (hour_in),
        .q         (tod_q),
        .day_carry (day_adv)
    );

    cal_date_core u_date (
        .clk      (clk),
        .rst      (rst),
        .adv      (day_adv),
        .wr_date  (wr_date),
        .wr_wday  (wr_wday),
        .wr_month (wr_month),
        .wr_year  (wr_year),
        .wdata    (wdata),
        .q        (cal_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode12_q <= 1'b0;
            stop_q   <= 1'b0;
            flag_q   <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                mode12_q <= wdata[CTRL_MODE12_BIT];
                stop_q   <= wdata[CTRL_STOP_BIT];
            end
            if (osc_fail)    flag_q <= 1'b1;
            else if (wr_sec) flag_q <= wdata[7];
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (addr)
            ADDR_W'(A_CTRL):  begin
                rdata[CTRL_MODE12_BIT] = mode12_q;
                rdata[CTRL_STOP_BIT]   = stop_q;
            end
            ADDR_W'(A_SEC):   rdata = {flag_q, tod_q.sec[6:0]};
            ADDR_W'(A_MIN):   rdata = tod_q.min;
            ADDR_W'(A_HOUR):  rdata = mode12_q ? hour_to_12(tod_q.hour) : tod_q.hour;
            ADDR_W'(A_DATE):  rdata = cal_q.date;
            ADDR_W'(A_WDAY):  rdata = {5'b00000, cal_q.wday};
            ADDR_W'(A_MONTH): rdata = cal_q.month;
            ADDR_W'(A_YEAR):  rdata = cal_q.year;
            default:          rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_checker.sv
module bcd_calendar_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              tick_in,
    input logic              osc_fail,
    input logic              stop_q,
    input logic              sec_adv,
    input logic              day_adv,
    input logic              flag_q,
    input logic [7:0]        secs,
    input logic [7:0]        mins,
    input logic [2:0]        wday
);
    // R13: a failing oscillator always leaves the flag set
    p_flag_set_r13: assert property (@(posedge clk) disable iff (rst)
        osc_fail |=> flag_q);

    // R13: seconds write with bit 7 low clears the flag
    p_flag_clear_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(3) && !wdata[7] && !osc_fail) |=> !flag_q);

    // R11: stopped and untouched time does not move
    p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !wr_en) |=> ($stable(secs) && $stable(mins)));

    // R3: without a tick the seconds stay put
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick_in && !wr_en) |=> $stable(secs));

    // R4: advance from 59 wraps to 00
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (sec_adv && secs == 8'h59 && !wr_en) |=> (secs == 8'h00));

    // R8: weekday moves whenever the date carries
    p_wday_step_r8: assert property (@(posedge clk) disable iff (rst)
        (day_adv && !wr_en) |=> (wday != $past(wday)));
endmodule

bind bcd_calendar bcd_calendar_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .tick_in  (tick_in),
    .osc_fail (osc_fail),
    .stop_q   (stop_q),
    .sec_adv  (sec_adv),
    .day_adv  (day_adv),
    .flag_q   (flag_q),
    .secs     (tod_q.sec),
    .mins     (tod_q.min),
    .wday     (cal_q.wday)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
    localparam int ADDR_W = 5;
    localparam int TPS    = 4;
    localparam int NVEC   = 12;

    // {sec,min,hour,date,wday,month,year} loaded, then expected one second later
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h00_00_00_01_00_01_24, 56'h01_00_00_01_00_01_24},
        {56'h59_00_00_01_00_01_24, 56'h00_01_00_01_00_01_24},
        {56'h59_59_10_15_03_06_24, 56'h00_00_11_15_03_06_24},
        {56'h59_59_23_31_06_01_23, 56'h00_00_00_01_00_02_23},
        {56'h59_59_23_28_02_02_23, 56'h00_00_00_01_03_03_23},
        {56'h59_59_23_28_03_02_24, 56'h00_00_00_29_04_02_24},
        {56'h59_59_23_29_04_02_24, 56'h00_00_00_01_05_03_24},
        {56'h59_59_23_30_01_04_25, 56'h00_00_00_01_02_05_25},
        {56'h59_59_23_31_02_12_99, 56'h00_00_00_01_03_01_00},
        {56'h59_59_23_30_05_11_19, 56'h00_00_00_01_06_12_19},
        {56'h59_59_23_31_04_08_20, 56'h00_00_00_01_05_09_20},
        {56'h59_59_23_28_01_02_00, 56'h00_00_00_29_02_02_00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_in = 1'b0;
    logic osc_fail = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_calendar #(.ADDR_W(ADDR_W), .TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .osc_fail(osc_fail),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic string vtag(input int i);
        case (i)
            0:             return "R3";
            1, 2:          return "R4";
            3, 7, 9, 10:   return "R5";
            4, 5, 6, 11:   return "R6";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic rd_check(input string tag, input int a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 reset state and map
        rd_check("R1 sec+flag", 3, 8'h80);
        rd_check("R1 min", 4, 8'h00);
        rd_check("R1 hour", 5, 8'h00);
        rd_check("R1 date", 6, 8'h01);
        rd_check("R1 wday", 7, 8'h00);
        rd_check("R1 month", 8, 8'h01);
        rd_check("R1 year", 9, 8'h00);
        rd_check("R2 ctrl", 0, 8'h00);
        rd_check("R2 unmapped", 1, 8'h00);

        // table walk: load one second before a boundary, advance, read back
        for (int i = 0; i < NVEC; i++) begin
            for (int f = 0; f < 7; f++) wr(3 + f, VEC[i][111 - 8*f -: 8]);
            ticks(TPS);
            for (int f = 0; f < 7; f++) begin
                rd(3 + f, v);
                check($sformatf("%s vector %0d field %0d", vtag(i), i, f), v, VEC[i][55 - 8*f -: 8]);
            end
        end
        // R8 weekday wrap 6 -> 0 already covered by vector 3; direct check too
        wr(7, 8'h06); wr(5, 8'h23); wr(4, 8'h59); wr(3, 8'h59);
        ticks(TPS);
        rd_check("R8 wday wrap", 7, 8'h00);

        // R3 / R12 prescaler phase and write effect
        wr(3, 8'h00);
        ticks(TPS - 1);
        rd_check("R3 short of a second", 3, 8'h00);
        wr(3, 8'h10);
        rd_check("R12 write immediate", 3, 8'h10);
        ticks(1);
        rd_check("R12 phase cleared", 3, 8'h10);
        ticks(TPS - 1);
        rd_check("R12 R3 full second", 3, 8'h11);

        // R11 stop
        wr(0, 8'h20);
        rd_check("R2 R11 stop bit", 0, 8'h20);
        ticks(2 * TPS);
        rd_check("R11 frozen", 3, 8'h11);
        wr(0, 8'h00);
        ticks(TPS);
        rd_check("R11 resumed", 3, 8'h12);

        // R9 12-hour read encoding
        wr(5, 8'h13); wr(0, 8'h08);
        rd_check("R9 13h", 5, 8'h21);
        wr(0, 8'h00); wr(5, 8'h00); wr(0, 8'h08);
        rd_check("R9 midnight", 5, 8'h12);
        wr(0, 8'h00); wr(5, 8'h12); wr(0, 8'h08);
        rd_check("R9 noon", 5, 8'h32);
        wr(0, 8'h00); wr(5, 8'h09); wr(0, 8'h08);
        rd_check("R9 morning", 5, 8'h09);

        // R10 12-hour write encoding
        wr(5, 8'h31); wr(0, 8'h00);
        rd_check("R10 11pm", 5, 8'h23);
        wr(0, 8'h08); wr(5, 8'h12); wr(0, 8'h00);
        rd_check("R10 12am", 5, 8'h00);
        wr(0, 8'h08); wr(5, 8'h32); wr(0, 8'h00);
        rd_check("R10 12pm", 5, 8'h12);
        wr(0, 8'h08); wr(5, 8'h31); wr(4, 8'h59); wr(3, 8'h59);
        ticks(TPS);
        rd_check("R9 R4 rollover to 12am", 5, 8'h12);
        wr(0, 8'h00);

        // R13 integrity flag
        @(negedge clk); osc_fail = 1'b1;
        @(negedge clk); osc_fail = 1'b0;
        rd(3, v);
        check("R13 flag set", v & 8'h80, 8'h80);
        wr(3, 8'h05);
        rd_check("R13 flag cleared", 3, 8'h05);
        wr(3, 8'h85);
        rd_check("R13 flag written high", 3, 8'h85);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule